// File: doc/BRIEF.md
# Conversion Trigger Controller

This block decides the moment at which an analog-to-digital conversion begins. Software sets up a source-select field, an auto-trigger enable, a converter enable and a channel-select value through plain write strobes. The block then issues a one-cycle start pulse. The pulse comes from a manual start strobe or from a rising edge on the flag picked by the source-select field. Source value 0 is free-running: each completed conversion starts the next one. Values 1 to 7 pick one of seven external flag inputs.

The rising-edge detector looks at the output of the source multiplexer, not at each flag. Moving the selection from a low flag to a high flag therefore counts as an edge. A busy output covers the whole conversion. A sticky completion flag records the converter's done pulse and serves as the flag for source 0. A channel-select write that arrives during a conversion is held back and applied when that conversion ends.

The block carries no data stream, so there is no valid/ready interface. Every pin is a plain control or status level or strobe, sampled on the rising clock edge.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset, conv_start, busy, done_flag and chan_sel are 0. The source field is 0, and auto-trigger and converter enable are both cleared.
- R2: With converter enable set and the block idle, a start_req pulse makes conv_start high for exactly one cycle, in the cycle after the request. busy rises in that same cycle. With converter enable cleared, no start pulse is ever produced.
- R3: While auto-trigger enable is cleared, edges on the flag inputs and changes of the source field start no conversion.
- R4: With auto-trigger and converter enable set and source value s in 1..7, a rising edge of ext_flags[s-1] gives conv_start one cycle after the cycle in which the flag first reads high.
- R5: With auto-trigger enabled, changing the source field from a source whose flag is low to one whose flag is high starts a conversion. conv_start rises one cycle after the new source value takes effect.
- R6: Writing the source field to 0 produces no start, even while done_flag is high.
- R7: In free-running mode (source 0, auto-trigger and converter enable set), a conv_done pulse during a conversion gives conv_start in the next cycle, and busy stays high.
- R8: start_req pulses and flag edges that arrive while busy is high are dropped and never start a conversion later.
- R9: A conv_done pulse while busy sets done_flag and, outside free-running restart, clears busy in the next cycle. A done_clr pulse clears done_flag. If both come in the same cycle, setting wins.
- R10: A channel-select write while idle shows on chan_sel in the next cycle. A write while busy leaves chan_sel unchanged until conv_done. The value is then applied in the same cycle that done_flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_flags | input | 7 | External flags for source values 1..7 (bit s-1 for value s) |
| wr_src | input | 1 | Strobe that writes the source-select field |
| wr_src_data | input | 3 | New source-select value |
| wr_auto | input | 1 | Strobe that writes auto-trigger enable |
| wr_auto_data | input | 1 | New auto-trigger enable |
| wr_en | input | 1 | Strobe that writes converter enable |
| wr_en_data | input | 1 | New converter enable |
| wr_chan | input | 1 | Strobe that writes channel select |
| wr_chan_data | input | 1 | New channel-select value |
| start_req | input | 1 | Manual start strobe |
| done_clr | input | 1 | Write-one-to-clear strobe for done_flag |
| conv_done | input | 1 | Conversion-complete pulse from the converter |
| conv_start | output | 1 | One-cycle conversion start pulse |
| busy | output | 1 | Conversion in progress |
| done_flag | output | 1 | Sticky completion flag, also the source-0 flag |
| chan_sel | output | 1 | Channel select currently in force |

## Verification
The assertions assume that conv_done comes only while busy is high, as a one-cycle pulse from a converter that answers the start it received. Pulses at other times are ignored by the block, but the properties on busy and done_flag are written for a well-behaved converter. The random stimulus drives conv_done only while the bench's reference model says a conversion is running. Flags, strobes and configuration writes are applied freely, so edges while busy, source switches and clear/set collisions all occur.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int unsigned DEF_SRC_W  = 3;
  localparam int unsigned DEF_CHAN_W = 1;

  typedef enum logic {
    CH_SETTLED = 1'b0,
    CH_WAITING = 1'b1
  } chan_state_e;

  function automatic logic is_free_run(input logic [DEF_SRC_W-1:0] s);
    return s == '0;
  endfunction
endpackage

// File: rtl/adc_trig_cfg.sv
module adc_trig_cfg
  import adc_trig_pkg::*;
#(
  parameter int unsigned SRC_W  = DEF_SRC_W,
  parameter int unsigned CHAN_W = DEF_CHAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_src,
  input  logic [SRC_W-1:0]  wr_src_data,
  input  logic              wr_auto,
  input  logic              wr_auto_data,
  input  logic              wr_en,
  input  logic              wr_en_data,
  input  logic              wr_chan,
  input  logic [CHAN_W-1:0] wr_chan_data,
  input  logic              busy,
  input  logic              conv_done,
  output logic [SRC_W-1:0]  src_q,
  output logic              auto_q,
  output logic              en_q,
  output logic [CHAN_W-1:0] chan_q
);
  logic [CHAN_W-1:0] pend_q;
  chan_state_e       pend_st;
  logic              finishing;

  assign finishing = busy & conv_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      auto_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (wr_src)  src_q  <= wr_src_data;
      if (wr_auto) auto_q <= wr_auto_data;
      if (wr_en)   en_q   <= wr_en_data;
    end
  end

  // channel select: direct when idle, deferred to completion when busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q  <= '0;
      pend_q  <= '0;
      pend_st <= CH_SETTLED;
    end else if (wr_chan && !busy) begin
      chan_q  <= wr_chan_data;
      pend_st <= CH_SETTLED;
    end else if (finishing) begin
      if (wr_chan)                      chan_q <= wr_chan_data;
      else if (pend_st == CH_WAITING)   chan_q <= pend_q;
      pend_st <= CH_SETTLED;
    end else if (wr_chan) begin
      pend_q  <= wr_chan_data;
      pend_st <= CH_WAITING;
    end
  end

  // R10: channel frozen for the length of a conversion
  p_chan_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !conv_done |=> $stable(chan_q));
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge
  import adc_trig_pkg::*;
#(
  parameter int unsigned SRC_W = DEF_SRC_W,
  localparam int unsigned NUM_EXT = (1 << SRC_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_flags,
  input  logic               done_flag,
  input  logic [SRC_W-1:0]   src,
  input  logic               auto_en,
  output logic               edge_trig,
  output logic               free_mode
);
  logic [NUM_EXT:0] flag_vec;
  logic             sel_flag;
  logic             sel_prev_q;

  assign flag_vec  = {ext_flags, done_flag};
  assign sel_flag  = flag_vec[src];
  assign free_mode = (src == '0);

  // history follows the mux output, so a source switch can form an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_prev_q <= 1'b0;
    else        sel_prev_q <= sel_flag;
  end

  assign edge_trig = auto_en & ~free_mode & sel_flag & ~sel_prev_q;
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic edge_trig,
  input  logic auto_en,
  input  logic conv_en,
  input  logic free_mode,
  input  logic conv_done,
  input  logic done_clr,
  output logic conv_start,
  output logic busy,
  output logic done_flag
);
  logic start_q, busy_q, done_q;
  logic free_trig, fire;

  assign free_trig = auto_en & free_mode & conv_done & busy_q;
  assign fire      = conv_en & ((~busy_q & (start_req | edge_trig)) | free_trig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      start_q <= fire;
      busy_q  <= fire | (busy_q & ~conv_done);
      done_q  <= (busy_q & conv_done) | (done_q & ~done_clr);
    end
  end

  assign conv_start = start_q;
  assign busy       = busy_q;
  assign done_flag  = done_q;

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |=> !conv_start);
  p_auto_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en && !start_req |=> !conv_start);
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !conv_done |=> !conv_start);
  p_done_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && conv_done |=> done_flag);
  p_freerun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && conv_done && auto_en && free_mode && conv_en |=> conv_start && busy);
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int unsigned SRC_W  = DEF_SRC_W,
  parameter int unsigned CHAN_W = DEF_CHAN_W,
  localparam int unsigned NUM_EXT = (1 << SRC_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_flags,
  input  logic               wr_src,
  input  logic [SRC_W-1:0]   wr_src_data,
  input  logic               wr_auto,
  input  logic               wr_auto_data,
  input  logic               wr_en,
  input  logic               wr_en_data,
  input  logic               wr_chan,
  input  logic [CHAN_W-1:0]  wr_chan_data,
  input  logic               start_req,
  input  logic               done_clr,
  input  logic               conv_done,
  output logic               conv_start,
  output logic               busy,
  output logic               done_flag,
  output logic [CHAN_W-1:0]  chan_sel
);
  logic [SRC_W-1:0] src_q;
  logic auto_q, en_q, edge_trig, free_mode;

  adc_trig_cfg #(.SRC_W(SRC_W), .CHAN_W(CHAN_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_src(wr_src), .wr_src_data(wr_src_data),
    .wr_auto(wr_auto), .wr_auto_data(wr_auto_data),
    .wr_en(wr_en), .wr_en_data(wr_en_data),
    .wr_chan(wr_chan), .wr_chan_data(wr_chan_data),
    .busy(busy), .conv_done(conv_done),
    .src_q(src_q), .auto_q(auto_q), .en_q(en_q), .chan_q(chan_sel)
  );

  adc_trig_edge #(.SRC_W(SRC_W)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .ext_flags(ext_flags), .done_flag(done_flag),
    .src(src_q), .auto_en(auto_q),
    .edge_trig(edge_trig), .free_mode(free_mode)
  );

  adc_trig_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_req(start_req), .edge_trig(edge_trig),
    .auto_en(auto_q), .conv_en(en_q), .free_mode(free_mode),
    .conv_done(conv_done), .done_clr(done_clr),
    .conv_start(conv_start), .busy(busy), .done_flag(done_flag)
  );

  // R6: free-running selection never self-starts; only manual or completion restarts
  p_free_no_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    free_mode && !start_req && !(busy && conv_done) |=> !conv_start);
endmodule

// File: tb/adc_trig_ctrl_tb.sv
`timescale 1ns/1ps
module adc_trig_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] ext_flags = '0;
  logic       wr_src = 0, wr_auto = 0, wr_en = 0, wr_chan = 0;
  logic [2:0] wr_src_data = '0;
  logic       wr_auto_data = 0, wr_en_data = 0;
  logic [0:0] wr_chan_data = '0;
  logic       start_req = 0, done_clr = 0, conv_done = 0;
  logic       conv_start, busy, done_flag;
  logic [0:0] chan_sel;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference model state
  logic [2:0] m_src;
  logic m_auto, m_en, m_prev, m_start, m_busy, m_done, m_chan, m_pend, m_pendv;

  always #2.5 clk = ~clk;

  adc_trig_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_flags(ext_flags),
    .wr_src(wr_src), .wr_src_data(wr_src_data),
    .wr_auto(wr_auto), .wr_auto_data(wr_auto_data),
    .wr_en(wr_en), .wr_en_data(wr_en_data),
    .wr_chan(wr_chan), .wr_chan_data(wr_chan_data),
    .start_req(start_req), .done_clr(done_clr), .conv_done(conv_done),
    .conv_start(conv_start), .busy(busy), .done_flag(done_flag), .chan_sel(chan_sel)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic sel_flag(input logic [2:0] s, input logic [6:0] f, input logic d);
    logic [7:0] v;
    v = {f, d};
    return v[s];
  endfunction

  task automatic mdl_reset();
    m_src = '0; m_auto = 0; m_en = 0; m_prev = 0; m_start = 0;
    m_busy = 0; m_done = 0; m_chan = 0; m_pend = 0; m_pendv = 0;
  endtask

  task automatic mdl_update();
    logic mux, edg, fr, fire, fin;
    mux  = sel_flag(m_src, ext_flags, m_done);
    edg  = m_auto && (m_src != 0) && mux && !m_prev;
    fin  = m_busy && conv_done;
    fr   = m_auto && (m_src == 0) && fin;
    fire = m_en && ((!m_busy && (start_req || edg)) || fr);
    if (wr_chan && !m_busy) begin m_chan = wr_chan_data[0]; m_pendv = 0; end
    else if (fin) begin
      if (wr_chan) m_chan = wr_chan_data[0];
      else if (m_pendv) m_chan = m_pend;
      m_pendv = 0;
    end else if (wr_chan) begin m_pend = wr_chan_data[0]; m_pendv = 1; end
    m_done  = fin || (m_done && !done_clr);
    m_busy  = fire || (m_busy && !conv_done);
    m_start = fire;
    m_prev  = mux;
    if (wr_src)  m_src  = wr_src_data;
    if (wr_auto) m_auto = wr_auto_data;
    if (wr_en)   m_en   = wr_en_data;
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge, strobes drop
  task automatic step();
    @(posedge clk);
    mdl_update();
    @(negedge clk);
    check("R2 conv_start", int'(conv_start), int'(m_start));
    check("R8 busy", int'(busy), int'(m_busy));
    check("R9 done_flag", int'(done_flag), int'(m_done));
    check("R10 chan_sel", int'(chan_sel), int'(m_chan));
    wr_src = 0; wr_auto = 0; wr_en = 0; wr_chan = 0;
    start_req = 0; done_clr = 0; conv_done = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2468));
    mdl_reset();
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 conv_start", int'(conv_start), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done_flag", int'(done_flag), 0);
    check("R1 chan_sel", int'(chan_sel), 0);

    // R2 manual start is ignored while disabled
    start_req = 1; step();
    check("R2 disabled", int'(conv_start), 0);
    wr_en = 1; wr_en_data = 1; step();
    start_req = 1; step();
    check("R2 start", int'(conv_start), 1);
    check("R2 busy rise", int'(busy), 1);
    step();
    check("R2 one cycle", int'(conv_start), 0);
    start_req = 1; step();
    check("R8 ignored", int'(conv_start), 0);
    wr_chan = 1; wr_chan_data = 1; step();
    check("R10 held", int'(chan_sel), 0);
    step();
    check("R8 not queued", int'(conv_start), 0);
    conv_done = 1; step();
    check("R9 busy clear", int'(busy), 0);
    check("R9 done set", int'(done_flag), 1);
    check("R10 applied", int'(chan_sel), 1);
    done_clr = 1; step();
    check("R9 cleared", int'(done_flag), 0);

    // R3 auto-trigger off
    wr_src = 1; wr_src_data = 3'd2; step();
    ext_flags[1] = 1; step(); step();
    check("R3 no trigger", int'(conv_start), 0);
    ext_flags[1] = 0; step();

    // R4 flag edge with auto-trigger on
    wr_auto = 1; wr_auto_data = 1; step();
    ext_flags[1] = 1; step();
    check("R4 edge start", int'(conv_start), 1);
    step(); conv_done = 1; step();
    ext_flags[1] = 0; step();

    // R5 switch low -> high source
    ext_flags[2] = 1; step();
    check("R5 no edge yet", int'(conv_start), 0);
    wr_src = 1; wr_src_data = 3'd3; step();
    step();
    check("R5 switch start", int'(conv_start), 1);
    step(); conv_done = 1; step();

    // R6 switch to free-running with done_flag high
    check("R6 flag high", int'(done_flag), 1);
    wr_src = 1; wr_src_data = 3'd0; step();
    for (int i = 0; i < 3; i++) begin
      step();
      check("R6 no start", int'(conv_start), 0);
    end

    // R7 free-running restart
    start_req = 1; step();
    step(); step();
    conv_done = 1; step();
    check("R7 restart", int'(conv_start), 1);
    check("R7 busy held", int'(busy), 1);
    wr_auto = 1; wr_auto_data = 0; step();
    conv_done = 1; step();
    check("R9 stop", int'(busy), 0);

    // constrained random phase checked against the model
    for (int i = 0; i < 4000; i++) begin
      ext_flags = ext_flags ^ (7'($urandom()) & 7'($urandom()) & 7'($urandom()));
      if ($urandom_range(15) == 0) begin wr_src = 1; wr_src_data = 3'($urandom()); end
      if ($urandom_range(31) == 0) begin wr_auto = 1; wr_auto_data = ($urandom_range(3) != 0); end
      if ($urandom_range(31) == 0) begin wr_en = 1; wr_en_data = ($urandom_range(3) != 0); end
      if ($urandom_range(7) == 0) begin wr_chan = 1; wr_chan_data = 1'($urandom()); end
      start_req = ($urandom_range(7) == 0);
      done_clr  = ($urandom_range(7) == 0);
      conv_done = m_busy && ($urandom_range(2) == 0);
      step();
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule